// File: doc/BRIEF.md
# Presence-Map Message Reconstructor

This block rebuilds a complete fixed-layout message record from a stream of decoded field beats. Each beat may carry one field value tagged with its slot index. The first accepted beat of a message also carries the presence map, which says which slots that message transmits. A beat flagged as the end of the message closes it.

Slots that the presence map marks as transmitted take the value delivered for them. Every other slot is filled from the record emitted for the previous message. A static per-slot operator picks how: either the old value is copied unchanged, or it is incremented by one. Closed records leave on a valid/ready channel. While a record waits for the consumer, the field input is stalled.

The previous-message state changes only at the instant a record is taken by the consumer. A stalled message therefore never disturbs the values that the next message will inherit.

Top module: `pmap_msg_rebuild`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1 and every stored previous-message value is zero. A first message with no slots present therefore emits 0 in copy slots and 1 in increment slots.
- R2: The presence map is sampled only on the opening beat of a message, which is the first accepted beat while no message is open. Bit i set means slot i is transmitted. `in_pmap` on any later beat of the same message is ignored.
- R3: An accepted beat with `in_fld_en`=1 whose `in_idx` names a present slot writes `in_data` into that slot. A later beat of the same message with the same index replaces the earlier value.
- R4: A field beat whose index names a slot absent from the sampled map has no effect on the record.
- R5: A slot marked present but never delivered before the end beat is emitted as zero.
- R6: An absent slot whose operator bit in `INC_MASK` is 0 is emitted with the value it had in the previous emitted record.
- R7: An absent slot whose operator bit in `INC_MASK` is 1 is emitted as the previous value plus one, modulo 2^FIELD_W (0xFFFF wraps to 0x0000 at the default width).
- R8: An accepted beat with `in_end`=1 closes the message, and `out_valid` rises on the next clock. The closing beat may also carry a field and may also be the opening beat. Slot i sits at `out_rec[i*FIELD_W +: FIELD_W]`.
- R9: While `out_valid` is 1 and `out_ready` is 0, `in_ready` stays 0, no input beat is accepted, and `out_valid` and `out_rec` hold steady.
- R10: The stored previous-message values are replaced by the emitted record only in the cycle in which `out_valid` and `out_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Block can accept a beat |
| in_pmap | input | NUM_FIELDS | Presence map, used on the opening beat |
| in_fld_en | input | 1 | Beat carries a field value |
| in_idx | input | $clog2(NUM_FIELDS) | Slot index of the carried field |
| in_data | input | FIELD_W | Field value |
| in_end | input | 1 | Beat closes the message |
| out_valid | output | 1 | Completed record available |
| out_ready | input | 1 | Consumer takes the record |
| out_rec | output | NUM_FIELDS*FIELD_W | Completed record, slot i at bits i*FIELD_W upward |

## Verification
Two pairs of operations can fall in the same cycle. In the first, the closing beat also writes the last field, so capture and merge happen together. In the second, the opening beat is also the closing beat, so the presence map is sampled and used in one edge. Both are provoked by vectors that deliver a single field, or no field at all, on one beat. They are judged by comparing the whole emitted record with hand-computed values, including the wrap of an increment slot and a stalled record that is held for several cycles before the next message inherits from it.

// File: rtl/pmr_pkg.sv
package pmr_pkg;

   typedef enum logic {
      OP_COPY = 1'b0,
      OP_INC  = 1'b1
   } fld_op_e;

   function automatic fld_op_e op_of(input logic bit_val);
      return bit_val ? OP_INC : OP_COPY;
   endfunction

endpackage

// File: rtl/pmr_ctrl.sv
module pmr_ctrl #(
   parameter int NUM_FIELDS = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic                  in_end,
   input  logic [NUM_FIELDS-1:0] in_pmap,
   input  logic                  out_ready,
   output logic                  in_ready,
   output logic                  accept,
   output logic                  close,
   output logic                  emit,
   output logic                  open_o,
   output logic [NUM_FIELDS-1:0] pmap_cur,
   output logic                  out_valid
);

   logic                  open_q;
   logic [NUM_FIELDS-1:0] pmap_q;
   logic                  valid_q;

   assign in_ready  = !valid_q;
   assign accept    = in_valid && in_ready;
   assign close     = accept && in_end;
   assign emit      = valid_q && out_ready;
   assign open_o    = open_q;
   assign pmap_cur  = open_q ? pmap_q : in_pmap;
   assign out_valid = valid_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q  <= 1'b0;
         pmap_q  <= '0;
         valid_q <= 1'b0;
      end else begin
         if (accept && !open_q) pmap_q <= in_pmap;
         if (accept) open_q <= !in_end;
         if (close) valid_q <= 1'b1;
         else if (emit) valid_q <= 1'b0;
      end
   end

   // R8: a closing beat produces a record on the next clock
   p_close_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      close |=> out_valid);

   // R9: an unaccepted record stays offered
   p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> out_valid);

   // R2: the sampled map cannot change inside an open message
   p_pmap_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      open_q |=> $stable(pmap_q));

endmodule

// File: rtl/pmr_wdec.sv
module pmr_wdec #(
   parameter int NUM_FIELDS = 4,
   parameter int IDX_W      = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  accept,
   input  logic                  fld_en,
   input  logic [IDX_W-1:0]      idx,
   input  logic [NUM_FIELDS-1:0] pmap_cur,
   output logic [NUM_FIELDS-1:0] write
);

   for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_dec
      assign write[gi] = accept && fld_en && pmap_cur[gi] && (idx == IDX_W'(gi));
   end

   // R3: one beat writes at most one slot
   p_wr_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(write));

   // R4: no slot is written without an accepted field beat
   p_wr_needs_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(accept && fld_en) |-> (write == '0));

endmodule

// File: rtl/pmr_slot.sv
module pmr_slot
   import pmr_pkg::*;
#(
   parameter int      FIELD_W = 16,
   parameter fld_op_e OP      = OP_COPY
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               open_i,
   input  logic               accept_i,
   input  logic               write_i,
   input  logic [FIELD_W-1:0] data_i,
   input  logic               present_i,
   input  logic               close_i,
   input  logic               emit_i,
   output logic [FIELD_W-1:0] rec_o
);

   logic [FIELD_W-1:0] cap_q, cap_base, cap_nxt;
   logic [FIELD_W-1:0] prev_q, fill, merged, out_q;

   assign cap_base = open_i ? cap_q : '0;
   assign cap_nxt  = write_i ? data_i : cap_base;

   if (OP == OP_INC) begin : g_inc
      assign fill = prev_q + FIELD_W'(1);
      // R7: an absent increment slot emits the previous value plus one
      p_fill_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (close_i && !present_i) |=> (rec_o == FIELD_W'($past(prev_q) + FIELD_W'(1))));
   end else begin : g_copy
      assign fill = prev_q;
      // R6: an absent copy slot repeats the previous value
      p_fill_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (close_i && !present_i) |=> (rec_o == $past(prev_q)));
   end

   assign merged = present_i ? cap_nxt : fill;
   assign rec_o  = out_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_q  <= '0;
         prev_q <= '0;
         out_q  <= '0;
      end else begin
         if (accept_i) cap_q <= cap_nxt;
         if (close_i) out_q <= merged;
         if (emit_i) prev_q <= out_q;
      end
   end

   // R10: previous-message state moves only on an emission
   p_prev_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !emit_i |=> $stable(prev_q));

endmodule

// File: rtl/pmap_msg_rebuild.sv
module pmap_msg_rebuild
   import pmr_pkg::*;
#(
   parameter int                    NUM_FIELDS = 4,
   parameter int                    FIELD_W    = 16,
   parameter logic [NUM_FIELDS-1:0] INC_MASK   = 4'b1010,
   localparam int                   IDX_W      = $clog2(NUM_FIELDS),
   localparam int                   REC_W      = NUM_FIELDS * FIELD_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   output logic                  in_ready,
   input  logic [NUM_FIELDS-1:0] in_pmap,
   input  logic                  in_fld_en,
   input  logic [IDX_W-1:0]      in_idx,
   input  logic [FIELD_W-1:0]    in_data,
   input  logic                  in_end,
   output logic                  out_valid,
   input  logic                  out_ready,
   output logic [REC_W-1:0]      out_rec
);

   if (NUM_FIELDS < 2) begin : g_bad_fields
      $error("pmap_msg_rebuild: NUM_FIELDS must be at least 2");
   end
   if (FIELD_W < 1) begin : g_bad_width
      $error("pmap_msg_rebuild: FIELD_W must be positive");
   end

   logic                  accept, close, emit, open_q;
   logic [NUM_FIELDS-1:0] pmap_cur, write;

   pmr_ctrl #(.NUM_FIELDS(NUM_FIELDS)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_end    (in_end),
      .in_pmap   (in_pmap),
      .out_ready (out_ready),
      .in_ready  (in_ready),
      .accept    (accept),
      .close     (close),
      .emit      (emit),
      .open_o    (open_q),
      .pmap_cur  (pmap_cur),
      .out_valid (out_valid)
   );

   pmr_wdec #(.NUM_FIELDS(NUM_FIELDS), .IDX_W(IDX_W)) u_wdec (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .fld_en   (in_fld_en),
      .idx      (in_idx),
      .pmap_cur (pmap_cur),
      .write    (write)
   );

   for (genvar gs = 0; gs < NUM_FIELDS; gs++) begin : g_slot
      pmr_slot #(.FIELD_W(FIELD_W), .OP(op_of(INC_MASK[gs]))) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .open_i    (open_q),
         .accept_i  (accept),
         .write_i   (write[gs]),
         .data_i    (in_data),
         .present_i (pmap_cur[gs]),
         .close_i   (close),
         .emit_i    (emit),
         .rec_o     (out_rec[gs*FIELD_W +: FIELD_W])
      );
   end

   // R9: a held record keeps its contents
   p_rec_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> $stable(out_rec));

   // R9: no beat slips in while a record waits
   p_no_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !accept);

endmodule

// File: tb/pmap_msg_rebuild_tb.sv
module pmap_msg_rebuild_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, in_fld_en = 1'b0, in_end = 1'b0, out_ready = 1'b0;
   logic [3:0]  in_pmap = '0;
   logic [1:0]  in_idx = '0;
   logic [15:0] in_data = '0;
   logic        in_ready, out_valid;
   logic [63:0] out_rec;

   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pmap_msg_rebuild u_dut (
      .clk (clk), .rst_n (rst_n),
      .in_valid (in_valid), .in_ready (in_ready), .in_pmap (in_pmap),
      .in_fld_en (in_fld_en), .in_idx (in_idx), .in_data (in_data), .in_end (in_end),
      .out_valid (out_valid), .out_ready (out_ready), .out_rec (out_rec)
   );

   typedef struct packed {
      logic [3:0]  pm;
      logic [3:0]  dm;
      logic [63:0] v;
      logic [63:0] e;
   } vec_t;

   // slot 3 is the leftmost 16 bits; slots 1 and 3 increment
   localparam vec_t TBL [6] = '{
      '{4'b1111, 4'b1111, 64'h4444_3333_2222_1111, 64'h4444_3333_2222_1111},
      '{4'b0000, 4'b0000, 64'h0,                   64'h4445_3333_2223_1111},
      '{4'b0101, 4'b0101, 64'h0000_BBBB_0000_AAAA, 64'h4446_BBBB_2224_AAAA},
      '{4'b1010, 4'b1010, 64'h0005_0000_FFFF_0000, 64'h0005_BBBB_FFFF_AAAA},
      '{4'b0000, 4'b0000, 64'h0,                   64'h0006_BBBB_0000_AAAA},
      '{4'b0011, 4'b0001, 64'h0000_0000_0000_0102, 64'h0007_BBBB_0000_0102}
   };

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic send_beat(input logic [3:0] pm, input logic fe, input logic [1:0] ix,
                            input logic [15:0] d, input logic e);
      in_valid = 1'b1; in_pmap = pm; in_fld_en = fe; in_idx = ix; in_data = d; in_end = e;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0; in_fld_en = 1'b0; in_end = 1'b0;
   endtask

   task automatic collect(input string tag, input logic [63:0] exp, input int stall);
      check({tag, " out_valid after close (R8)"}, 64'(out_valid), 64'd1);
      check({tag, " record"}, out_rec, exp);
      for (int k = 0; k < stall; k++) begin
         in_valid = 1'b1; in_fld_en = 1'b1; in_end = 1'b1; in_pmap = 4'hF; in_data = 16'hBAD0;
         @(posedge clk);
         @(negedge clk);
         check({tag, " R9 held valid"}, 64'(out_valid), 64'd1);
         check({tag, " R9 in_ready low"}, 64'(in_ready), 64'd0);
         check({tag, " R9 record stable"}, out_rec, exp);
      end
      in_valid = 1'b0; in_fld_en = 1'b0; in_end = 1'b0;
      out_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      out_ready = 1'b0;
      check({tag, " released"}, 64'(out_valid), 64'd0);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1: reset state and zero previous values
      check("R1 out_valid", 64'(out_valid), 64'd0);
      check("R1 in_ready", 64'(in_ready), 64'd1);
      send_beat(4'b0000, 1'b0, 2'd0, 16'h0, 1'b1);
      collect("R1 zero history", 64'h0001_0000_0001_0000, 0);

      do_reset();
      // table: R3 R5 R6 R7 (wrap in entry 4) R8
      for (int t = 0; t < 6; t++) begin
         if (TBL[t].dm == 4'b0000) begin
            send_beat(TBL[t].pm, 1'b0, 2'd0, 16'h0, 1'b1);
         end else begin
            for (int f = 0; f < 4; f++) begin
               if (TBL[t].dm[f])
                  send_beat(TBL[t].pm, 1'b1, 2'(f), TBL[t].v[f*16 +: 16],
                            ((TBL[t].dm >> (f + 1)) == 4'b0000));
            end
         end
         collect($sformatf("R6 R7 vector %0d", t), TBL[t].e, 0);
      end

      // R2 and R4: later map ignored, absent-slot write dropped
      send_beat(4'b0001, 1'b1, 2'd0, 16'h0A0A, 1'b0);
      send_beat(4'b1111, 1'b1, 2'd2, 16'hDEAD, 1'b1);
      collect("R2 R4 late map", 64'h0008_BBBB_0001_0A0A, 0);

      // R3: repeated index, last value wins
      send_beat(4'b0100, 1'b1, 2'd2, 16'h1234, 1'b0);
      send_beat(4'b0100, 1'b1, 2'd2, 16'h5678, 1'b1);
      collect("R3 overwrite", 64'h0009_5678_0002_0A0A, 0);

      // R8 single beat opens and closes; R9 stall with input pressing
      send_beat(4'b1000, 1'b1, 2'd3, 16'h7777, 1'b1);
      collect("R8 R9 single beat", 64'h7777_5678_0003_0A0A, 3);

      // R10: history equals the stalled record once taken
      send_beat(4'b0000, 1'b0, 2'd0, 16'h0, 1'b1);
      collect("R10 history", 64'h7778_5678_0004_0A0A, 0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule